// File: doc/BRIEF.md
# Up/down center-aligned timebase counter

This block is the time reference for a group of compare channels. A prescaler divides the clock by a programmable ratio and produces one count tick for each period. On each tick the main counter steps against a reload limit. In edge-aligned mode it counts in one fixed direction. In the three center-aligned modes it runs up and down in turn. Each wrap or turnaround is an overflow/underflow occurrence. A repetition counter turns every (N+1)-th occurrence into an update event.

An update event copies the buffered prescaler, reload and repetition values into their working copies and pulses `update_o`. It also sets a sticky flag, `uif_o`. A software strobe forces the same transfer and restarts the counter and the prescaler. The block drives a qualification signal, `cc_qual_o`. It tells downstream compare logic whether the current counting direction may set compare flags in the selected mode.

Top module: `updn_timebase`

## Requirements
- R1: After reset, `cnt_o`=0, `dir_o`=0 (up), `run_o`=0, `update_o`=0 and `uif_o`=0.
- R2: While `run_o`=1 and `cnt_en_i`=1, the counter moves exactly once every PSC+1 clocks, where PSC is the prescaler working value. With `cnt_en_i`=0 the counter holds. A newly written prescaler value does not change the cadence until the next update event.
- R3: Alignment code 00 is edge mode, with direction set by `cfg_dir_i` (0 up, 1 down). Counting up runs 0..ARR and then goes to 0 with an update. Counting down runs ARR..0 and then goes to ARR with an update.
- R4: Alignment codes 01, 10 and 11 are center modes and ignore `cfg_dir_i`. The counter runs 0,1..ARR,ARR-1..1,0,1,… and never repeats an end value. Each turnaround is an overflow/underflow occurrence, and `dir_o` reads 1 while counting down.
- R5: `cc_qual_o` is 1 in codes 00 and 11. It equals `dir_o` in code 01 (down only) and equals the inverse of `dir_o` in code 10 (up only).
- R6: With `cfg_arpe_i`=0 a reload write acts on the next tick. With `cfg_arpe_i`=1 it takes effect only at the next update event.
- R7: With repetition value REP, an update event occurs on every (REP+1)-th overflow/underflow occurrence, counted from the last software update.
- R8: While `cfg_udis_i`=1, occurrences produce no `update_o`, no flag and no transfer of buffered values.
- R9: With `cfg_urs_i`=1, a software update still pulses `update_o` and transfers values, but only counter occurrences set `uif_o`. With 0, both set it.
- R10: A `ug_i` strobe restarts the prescaler and loads the counter with 0, or with ARR in edge-down mode. In center modes the direction is set to up. Unless updates are disabled, `update_o` pulses on the next clock.
- R11: With `cfg_opm_i`=1, `run_o` clears on the same edge that issues an update event, and the counter then stays put.
- R12: `uif_o` stays set until a cycle with `flag_clr_i`=1 that has no new update. A new update wins over the clear.
- R13: While the reload working value is 0, the counter holds and no occurrence is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load all cfg_* fields |
| cfg_en_i | input | 1 | Counter enable |
| cfg_dir_i | input | 1 | Edge-mode direction, 1 = down |
| cfg_align_i | input | 2 | Alignment code |
| cfg_opm_i | input | 1 | Stop at next update |
| cfg_udis_i | input | 1 | Update disable |
| cfg_urs_i | input | 1 | Flag only on counter occurrences |
| cfg_arpe_i | input | 1 | Buffer reload until update |
| psc_we_i | input | 1 | Prescaler write strobe |
| psc_i | input | PSC_W | Prescaler value |
| arr_we_i | input | 1 | Reload write strobe |
| arr_i | input | CNT_W | Reload value |
| rep_we_i | input | 1 | Repetition write strobe |
| rep_i | input | REP_W | Repetition value |
| ug_i | input | 1 | Software update strobe |
| flag_clr_i | input | 1 | Clear update flag |
| cnt_en_i | input | 1 | External count enable |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Current direction, 1 = down |
| run_o | output | 1 | Enable state |
| update_o | output | 1 | Update event pulse |
| uif_o | output | 1 | Sticky update flag |
| cc_qual_o | output | 1 | Compare-flag qualification |

## Verification
A corrupted prescaler count or turnaround decision appears on `cnt_o` within one tick period, either as a skipped end value or as a wrong step. A corrupted repetition count moves the `update_o` pulse by at least one occurrence, and the error shows by the end of the next REP+1 occurrences. A stale or wrong direction state shows at once on `dir_o` and `cc_qual_o`, and on the value that follows the next turnaround. Sweeps over each alignment code, direction, small PSC, ARR and REP compare every clock against values the bench derives from the tick count.

// File: rtl/updn_timebase_pkg.sv
package updn_timebase_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE    = 2'b00,
    ALIGN_CTR_DN  = 2'b01,
    ALIGN_CTR_UP  = 2'b10,
    ALIGN_CTR_ALL = 2'b11
  } align_e;

  typedef struct packed {
    logic   en;
    logic   dir;
    align_e align;
    logic   opm;
    logic   udis;
    logic   urs;
    logic   arpe;
  } tb_cfg_t;
endpackage

// File: rtl/updn_tb_prescaler.sv
module updn_tb_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             xfer_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_pre_q, psc_sh_q, pcnt_q;

  assign tick_o = run_i && !restart_i && (pcnt_q == psc_sh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_pre_q <= '0;
      psc_sh_q  <= '0;
      pcnt_q    <= '0;
    end else begin
      if (psc_we_i) psc_pre_q <= psc_i;
      if (xfer_i)   psc_sh_q  <= psc_pre_q;
      if (restart_i)  pcnt_q <= '0;
      else if (run_i) pcnt_q <= tick_o ? '0 : pcnt_q + PSC_W'(1);
    end
  end

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_sh_q != '0 && !xfer_i) |=> !tick_o);
endmodule

// File: rtl/updn_tb_core.sv
module updn_tb_core
  import updn_timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             xfer_i,
  input  align_e           align_i,
  input  logic             cfg_dir_i,
  input  logic             arpe_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, arr_pre_q, arr_sh_q, reload_val;
  logic             dir_q, center, step, down;

  assign center     = (align_i != ALIGN_EDGE);
  assign down       = center ? dir_q : cfg_dir_i;
  assign step       = tick_i && !restart_i && (arr_sh_q != '0);
  assign reload_val = xfer_i ? arr_pre_q : arr_sh_q;
  assign cnt_o      = cnt_q;
  assign dir_o      = down;

  // occurrence: leaving an end value
  always_comb begin
    wrap_o = 1'b0;
    if (step) wrap_o = down ? (cnt_q == '0) : (cnt_q >= arr_sh_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      arr_pre_q <= '0;
      arr_sh_q  <= '0;
    end else begin
      if (arr_we_i) arr_pre_q <= arr_i;
      if (arr_we_i && !arpe_i) arr_sh_q <= arr_i;
      else if (xfer_i)         arr_sh_q <= arr_pre_q;

      if (restart_i) begin
        cnt_q <= (!center && cfg_dir_i) ? reload_val : '0;
        dir_q <= 1'b0;
      end else if (step) begin
        if (!center) begin
          if (cfg_dir_i) cnt_q <= wrap_o ? reload_val : cnt_q - CNT_W'(1);
          else           cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
        end else if (dir_q) begin
          if (wrap_o) begin
            cnt_q <= CNT_W'(1);
            dir_q <= 1'b0;
          end else cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          if (wrap_o) begin
            cnt_q <= arr_sh_q - CNT_W'(1);
            dir_q <= 1'b1;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
  assert_edge_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !center && !cfg_dir_i) |=> (cnt_q == '0));
  assert_center_no_repeat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && center) |=> (cnt_q != $past(cnt_q)));
  assert_zero_reload_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_sh_q == '0 && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/updn_tb_repgate.sv
module updn_tb_repgate #(
  parameter int unsigned REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             restart_i,
  input  logic             udis_i,
  input  logic             rep_we_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             uev_o,
  output logic             cnt_upd_o
);
  logic [REP_W-1:0] rep_pre_q, rep_sh_q, rcnt_q, reload_val;
  logic             rep_due;

  assign rep_due    = wrap_i && (rcnt_q == '0);
  assign uev_o      = !udis_i && (restart_i || rep_due);
  assign cnt_upd_o  = !udis_i && rep_due;
  assign reload_val = uev_o ? rep_pre_q : rep_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_pre_q <= '0;
      rep_sh_q  <= '0;
      rcnt_q    <= '0;
    end else begin
      if (rep_we_i) rep_pre_q <= rep_i;
      if (uev_o)    rep_sh_q  <= rep_pre_q;
      if (restart_i || rep_due) rcnt_q <= reload_val;
      else if (wrap_i)          rcnt_q <= rcnt_q - REP_W'(1);
    end
  end

  assert_rep_countdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && rcnt_q != '0 && !restart_i) |=> (rcnt_q == $past(rcnt_q) - REP_W'(1)));
endmodule

// File: rtl/updn_timebase.sv
module updn_timebase
  import updn_timebase_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic             cfg_dir_i,
  input  logic [1:0]       cfg_align_i,
  input  logic             cfg_opm_i,
  input  logic             cfg_udis_i,
  input  logic             cfg_urs_i,
  input  logic             cfg_arpe_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             rep_we_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             ug_i,
  input  logic             flag_clr_i,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             run_o,
  output logic             update_o,
  output logic             uif_o,
  output logic             cc_qual_o
);
  tb_cfg_t cfg_q;
  logic    tick, wrap, uev, cnt_upd, update_q, uif_q;

  updn_tb_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni,
    .run_i    (cfg_q.en && cnt_en_i),
    .restart_i(ug_i),
    .xfer_i   (uev),
    .psc_we_i, .psc_i,
    .tick_o   (tick)
  );

  updn_tb_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .restart_i(ug_i),
    .xfer_i   (uev),
    .align_i  (cfg_q.align),
    .cfg_dir_i(cfg_q.dir),
    .arpe_i   (cfg_q.arpe),
    .arr_we_i, .arr_i,
    .cnt_o,
    .dir_o,
    .wrap_o   (wrap)
  );

  updn_tb_repgate #(.REP_W(REP_W)) u_rep (
    .clk_i, .rst_ni,
    .wrap_i   (wrap),
    .restart_i(ug_i),
    .udis_i   (cfg_q.udis),
    .rep_we_i, .rep_i,
    .uev_o    (uev),
    .cnt_upd_o(cnt_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      update_q <= 1'b0;
      uif_q    <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        cfg_q.en    <= cfg_en_i;
        cfg_q.dir   <= cfg_dir_i;
        cfg_q.align <= align_e'(cfg_align_i);
        cfg_q.opm   <= cfg_opm_i;
        cfg_q.udis  <= cfg_udis_i;
        cfg_q.urs   <= cfg_urs_i;
        cfg_q.arpe  <= cfg_arpe_i;
      end
      if (cfg_q.opm && uev) cfg_q.en <= 1'b0;
      update_q <= uev;
      if (uev && (!cfg_q.urs || cnt_upd)) uif_q <= 1'b1;
      else if (flag_clr_i)                uif_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (cfg_q.align)
      ALIGN_CTR_DN: cc_qual_o = dir_o;
      ALIGN_CTR_UP: cc_qual_o = !dir_o;
      default:      cc_qual_o = 1'b1;
    endcase
  end

  assign run_o    = cfg_q.en;
  assign update_o = update_q;
  assign uif_o    = uif_q;

  assert_udis_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.udis |=> !update_o);
  assert_opm_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.opm && uev) |=> !run_o);
  assert_flag_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uif_o && !flag_clr_i) |=> uif_o);
  assert_ug_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug_i && !cfg_q.udis) |=> update_o);
endmodule

// File: tb/updn_timebase_tb_top.sv
module updn_timebase_tb_top;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int RW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_en_i = 0, cfg_dir_i = 0, cfg_opm_i = 0;
  logic cfg_udis_i = 0, cfg_urs_i = 0, cfg_arpe_i = 0;
  logic [1:0] cfg_align_i = '0;
  logic psc_we_i = 0, arr_we_i = 0, rep_we_i = 0, ug_i = 0, flag_clr_i = 0;
  logic cnt_en_i = 1;
  logic [PW-1:0] psc_i = '0;
  logic [CW-1:0] arr_i = '0;
  logic [RW-1:0] rep_i = '0;
  logic [CW-1:0] cnt_o;
  logic dir_o, run_o, update_o, uif_o, cc_qual_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  updn_timebase dut_i (.*);

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic drive_cfg(input int en, input int dir, input int al, input int opm,
                           input int udis, input int urs, input int arpe);
    cfg_en_i = en[0]; cfg_dir_i = dir[0]; cfg_align_i = al[1:0]; cfg_opm_i = opm[0];
    cfg_udis_i = udis[0]; cfg_urs_i = urs[0]; cfg_arpe_i = arpe[0]; cfg_we_i = 1;
  endtask

  task automatic setup(input int al, input int dir, input int p, input int a, input int r,
                       input int opm, input int udis, input int urs, input int arpe);
    drive_cfg(0, dir, al, opm, udis, urs, arpe);
    step(); cfg_we_i = 0;
    psc_we_i = 1; psc_i = PW'(p); arr_we_i = 1; arr_i = CW'(a); rep_we_i = 1; rep_i = RW'(r);
    step(); psc_we_i = 0; arr_we_i = 0; rep_we_i = 0;
    ug_i = 1;
    step(); ug_i = 0;
    chk("R10", "update after ug", update_o, udis == 0 ? 1 : 0);
    chk("R10", "cnt after ug", cnt_o, (al == 0 && dir == 1) ? a : 0);
    flag_clr_i = 1; drive_cfg(1, dir, al, opm, udis, urs, arpe);
    step(); flag_clr_i = 0; cfg_we_i = 0;
    chk("R12", "flag cleared", uif_o, 0);
  endtask

  task automatic sweep(input int al, input int dir, input int p, input int a, input int r);
    int t = 0, occ = 0, any = 0, n;
    setup(al, dir, p, a, r, 0, 0, 0, 0);
    n = (p + 1) * (4 * a + 4) * (r + 1) + 3;
    for (int k = 1; k <= n; k++) begin
      int upd = 0, ec, up, occ_n, eq;
      step();
      if (k % (p + 1) == 0) begin
        t++;
        occ_n = (al == 0) ? t / (a + 1) : (t - 1) / a;
        if (occ_n > occ && occ_n % (r + 1) == 0) upd = 1;
        occ = occ_n;
      end
      if (upd) any = 1;
      if (al == 0) begin
        ec = (dir == 0) ? t % (a + 1) : a - t % (a + 1);
        up = (dir == 0);
      end else begin
        ec = t % (2 * a);
        if (ec > a) ec = 2 * a - ec;
        up = (t == 0 || ((t - 1) % (2 * a)) < a) ? 1 : 0;
      end
      eq = (al == 1) ? !up : (al == 2) ? up : 1;
      chk(al == 0 ? "R3" : "R4", "cnt", cnt_o, ec);
      chk(r == 0 ? "R2" : "R7", "update", update_o, upd);
      chk("R12", "flag", uif_o, any);
      chk(al == 0 ? "R3" : "R4", "dir", dir_o, up ? 0 : 1);
      chk("R5", "qual", cc_qual_o, eq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1;
    #1;
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "dir", dir_o, 0);
    chk("R1", "run", run_o, 0);
    chk("R1", "update", update_o, 0);
    chk("R1", "flag", uif_o, 0);
    step();

    for (int al = 0; al < 4; al++)
      for (int dir = 0; dir < 2; dir++)
        for (int p = 0; p < 3; p++)
          for (int a = 1; a < 4; a++)
            for (int r = 0; r < 3; r += 2)
              sweep(al, dir, p, a, r);

    // R6 buffered reload
    setup(0, 0, 0, 5, 0, 0, 0, 0, 1);
    step(); step();
    arr_we_i = 1; arr_i = 2; step(); arr_we_i = 0;
    step(); step();
    chk("R6", "old limit kept", cnt_o, 5);
    step();
    chk("R6", "wrap at old limit", update_o, 1);
    step(); step();
    chk("R6", "new limit reached", cnt_o, 2);
    step();
    chk("R6", "wrap at new limit", cnt_o, 0);
    chk("R6", "update at new limit", update_o, 1);

    // R6 immediate reload
    setup(0, 0, 0, 5, 0, 0, 0, 0, 0);
    step(); step();
    arr_we_i = 1; arr_i = 2; step(); arr_we_i = 0;
    chk("R6", "cnt after write", cnt_o, 3);
    step();
    chk("R6", "immediate wrap", cnt_o, 0);
    chk("R6", "immediate update", update_o, 1);

    // R8 update disable
    setup(0, 0, 0, 2, 0, 0, 0, 0, 0);
    drive_cfg(1, 0, 0, 0, 1, 0, 0); psc_we_i = 1; psc_i = 3;
    step(); cfg_we_i = 0; psc_we_i = 0;
    for (int k = 2; k <= 10; k++) begin
      step();
      chk("R8", "cnt with psc untransferred", cnt_o, k % 3);
      chk("R8", "no update", update_o, 0);
      chk("R8", "no flag", uif_o, 0);
    end

    // R9 update source
    setup(0, 0, 0, 2, 0, 0, 0, 1, 0);
    step();
    ug_i = 1; step(); ug_i = 0;
    chk("R9", "ug pulse", update_o, 1);
    chk("R9", "ug no flag", uif_o, 0);
    chk("R10", "ug reinit", cnt_o, 0);
    step(); step(); step();
    chk("R9", "overflow pulse", update_o, 1);
    chk("R9", "overflow flag", uif_o, 1);

    // R10 restart, R2 buffered prescaler
    setup(0, 0, 0, 7, 0, 0, 0, 0, 0);
    step(); step(); step();
    psc_we_i = 1; psc_i = 2; step(); psc_we_i = 0;
    chk("R2", "psc not yet applied", cnt_o, 4);
    step();
    chk("R2", "psc not yet applied", cnt_o, 5);
    ug_i = 1; step(); ug_i = 0;
    chk("R10", "restart cnt", cnt_o, 0);
    step(); step();
    chk("R10", "prescaler restarted", cnt_o, 0);
    step();
    chk("R2", "new cadence", cnt_o, 1);

    // R2 external enable
    setup(0, 0, 0, 9, 0, 0, 0, 0, 0);
    step(); step();
    cnt_en_i = 0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R2", "held by cnt_en", cnt_o, 2);
    end
    cnt_en_i = 1; step();
    chk("R2", "resumes", cnt_o, 3);

    // R11 one-pulse, R12 sticky flag
    setup(0, 0, 0, 2, 0, 1, 0, 0, 0);
    step(); step();
    chk("R11", "running", run_o, 1);
    step();
    chk("R11", "update", update_o, 1);
    chk("R11", "stopped", run_o, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R11", "frozen", cnt_o, 0);
      chk("R12", "flag sticky", uif_o, 1);
    end
    flag_clr_i = 1; step(); flag_clr_i = 0;
    chk("R12", "flag cleared", uif_o, 0);

    // R13 zero reload
    setup(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R13", "cnt held", cnt_o, 0);
      chk("R13", "no update", update_o, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule